// File: doc/BRIEF.md
# Page Location Directory Controller

This block keeps a physically tagged, set-associative directory with one entry per page. Each entry records the page tag, a backing copy of that page's line location table (one slot per cache line giving the cache level and way), and a back-pointer. The back-pointer names the translation-buffer entry that owns the live copy of the table. At any moment exactly one copy of a page's table is authoritative. When the back-pointer is set, the buffer entry it names holds that copy. When it is clear, the directory's own copy does. Ownership moves from one buffer entry to another and is never duplicated.

A single request port carries four operations: a translation-buffer miss (issued after address translation), the write-back of a table when a buffer entry is evicted, the update for an L1 victim that moves to L2, and a coherence probe. The controller acts on the translation buffers through a command port. It can read a table, load a table and mark it valid, kill a table, or rewrite one slot. Read data comes back on a response handshake. A request that needs several commands runs as one atomic sequence while `busy` is high.

Top module: `page_loc_dir`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `tb_valid` are low and every directory entry is invalid, so a probe of any page answers hit=0 without issuing a buffer command.
- R2: A miss (op 0) that hits an entry with no owner issues one LOAD (tb_op 1) to the requester, carrying the directory's table. It answers hit=1 with the entry pointer {set, way}. From then on, probes of that page read the requester's table.
- R3: A miss that misses the directory installs the page with an all-zero (not cached) table and the requester as owner, then LOADs zeros into the requester. The victim way is the lowest invalid way. If there is none, it is the lowest way with no owner. If every way has an owner, a rotating pointer picks the way, starting at way 0. The controller KILLs (tb_op 2) the victim owner's table before the LOAD. It answers hit=0 with the new pointer.
- R4: A miss from buffer id B on a page owned by a different id A is a synonym hand-off. The controller issues, in this order, READ (tb_op 0) of A, LOAD of B with the returned table, and KILL of A, and then B becomes the owner. A repeated miss from the owner itself issues no command.
- R5: The hand-off of R4 also applies when an instruction-side requester (id MSB 1) misses on a page owned by a data-side entry (id MSB 0).
- R6: An eviction write-back (op 1) whose id matches the owner of the entry at `req_ptr` stores `req_tbl` into the directory, clears the owner, and answers hit=1. If the id does not match, the directory is left unchanged and the answer is hit=0.
- R7: An L1 victim update (op 2) rewrites slot `req_slot` of the page at `req_ptr` to level 2'b11 (L2) with way `req_way`. A slot is {level[1:0], way}, with the level in the top bits: 00 not cached, 01 L1 instruction, 10 L1 data, 11 L2. If the page has an owner, the rewrite is issued as a SLOT command (tb_op 3) to that owner. Otherwise the directory copy is rewritten and no command is issued.
- R8: A probe (op 3) that misses answers hit=0 and location 0. A hit on an entry with no owner returns the directory slot. A hit on an owned entry READs the owner's table and returns its slot.
- R9: While a sequence runs, `busy` is high and new requests are ignored. Each accepted request produces exactly one `rsp_valid` pulse, and buffer commands appear only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 miss, 1 evict write-back, 2 L1 victim, 3 probe |
| req_page | input | PAW | Physical page address (low bits select the set) |
| req_bid | input | BIDW | Buffer entry id, MSB set for the instruction side |
| req_ptr | input | PTRW | Directory pointer {set, way} for evict and victim |
| req_slot | input | LIW | Line slot within the page |
| req_way | input | LWAYW | New L2 way for a victim |
| req_tbl | input | TBLW | Table written back on evict |
| busy | output | 1 | A sequence is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Directory hit or ownership match |
| rsp_ptr | output | PTRW | Entry pointer for miss and probe |
| rsp_loc | output | SLOTW | Slot value returned by a probe |
| tb_valid | output | 1 | Buffer command strobe |
| tb_op | output | 2 | 0 read, 1 load, 2 kill, 3 slot write |
| tb_id | output | BIDW | Target buffer entry |
| tb_slot | output | LIW | Slot for a slot write |
| tb_loc | output | SLOTW | Slot value for a slot write |
| tb_tbl | output | TBLW | Table for a load |
| tb_rsp_valid | input | 1 | Read data valid |
| tb_rsp_tbl | input | TBLW | Table returned by a read |

## Verification
The bench builds the block with two sets of two ways, 4-bit page addresses, four lines per page, 2-bit L2 ways and eight buffer ids. This makes every page address sweepable, so a single set fills up within a handful of misses. That reaches the invalid-way, unowned-way and rotating-victim choices in turn. With eight ids, both synonym hand-off between data-side entries and the data-to-instruction transfer can be driven on one page. A behavioural model of the translation buffers lets each command sequence be compared, in order, against values computed from the requirements.

// File: rtl/page_loc_dir.sv
`timescale 1ns/1ps
module page_loc_dir #(
  parameter int PAW   = 28,
  parameter int SETS  = 512,
  parameter int WAYS  = 8,
  parameter int LINES = 16,
  parameter int LWAYW = 4,
  parameter int BIDW  = 7,
  localparam int SETW  = $clog2(SETS),
  localparam int WAYW  = $clog2(WAYS),
  localparam int PTRW  = SETW + WAYW,
  localparam int SLOTW = 2 + LWAYW,
  localparam int TBLW  = LINES * SLOTW,
  localparam int LIW   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [PAW-1:0]   req_page,
  input  logic [BIDW-1:0]  req_bid,
  input  logic [PTRW-1:0]  req_ptr,
  input  logic [LIW-1:0]   req_slot,
  input  logic [LWAYW-1:0] req_way,
  input  logic [TBLW-1:0]  req_tbl,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PTRW-1:0]  rsp_ptr,
  output logic [SLOTW-1:0] rsp_loc,
  output logic             tb_valid,
  output logic [1:0]       tb_op,
  output logic [BIDW-1:0]  tb_id,
  output logic [LIW-1:0]   tb_slot,
  output logic [SLOTW-1:0] tb_loc,
  output logic [TBLW-1:0]  tb_tbl,
  input  logic             tb_rsp_valid,
  input  logic [TBLW-1:0]  tb_rsp_tbl
);
  localparam int TAGW = PAW - SETW;
  localparam int ENT  = SETS * WAYS;
  localparam logic [1:0] OP_MISS = 2'd0, OP_EVICT = 2'd1, OP_VICT = 2'd2, OP_PROBE = 2'd3;
  localparam logic [1:0] TB_READ = 2'd0, TB_LOAD = 2'd1, TB_KILL = 2'd2, TB_SLOT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_RD, S_WR, S_INV} st_t;
  st_t st;

  logic [TAGW-1:0] d_tag [ENT];
  logic            d_v   [ENT];
  logic [TBLW-1:0] d_tab [ENT];
  logic            bp_v  [ENT];
  logic [BIDW-1:0] bp_id [ENT];

  logic [1:0]       op_q;
  logic [PAW-1:0]   pa_q;
  logic [BIDW-1:0]  bid_q, old_q;
  logic [PTRW-1:0]  ptr_q, eptr_q;
  logic [LIW-1:0]   slot_q;
  logic [LWAYW-1:0] way_q;
  logic [TBLW-1:0]  tbl_q;
  logic             syn_q;
  logic [WAYW-1:0]  rr;

  wire [SETW-1:0] set_q = pa_q[SETW-1:0];
  wire [TAGW-1:0] tag_q = pa_q[PAW-1:SETW];

  logic            hit, ffree, fownok;
  logic [WAYW-1:0] hway, fway, fown;
  logic [PTRW-1:0] idx;
  always_comb begin
    hit = 1'b0; hway = '0; ffree = 1'b0; fway = '0; fownok = 1'b0; fown = '0; idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      idx = {set_q, WAYW'(w)};
      if (d_v[idx] && d_tag[idx] == tag_q) begin hit = 1'b1; hway = WAYW'(w); end
      if (!d_v[idx]) begin ffree = 1'b1; fway = WAYW'(w); end
      if (d_v[idx] && !bp_v[idx]) begin fownok = 1'b1; fown = WAYW'(w); end
    end
  end

  wire [WAYW-1:0] vway = ffree ? fway : (fownok ? fown : rr);
  wire [PTRW-1:0] hent = {set_q, hway};
  wire [PTRW-1:0] vent = {set_q, vway};
  wire            vkill = d_v[vent] && bp_v[vent];

  assign busy = (st != S_IDLE);

  always_comb begin
    tb_valid = 1'b0; tb_op = TB_READ; tb_id = bid_q; tb_slot = slot_q;
    tb_loc = {2'b11, way_q}; tb_tbl = tbl_q;
    case (st)
      S_EXEC: case (op_q)
        OP_MISS:
          if (hit) begin
            if (!bp_v[hent]) begin tb_valid = 1'b1; tb_op = TB_LOAD; tb_tbl = d_tab[hent]; end
            else if (bp_id[hent] != bid_q) begin tb_valid = 1'b1; tb_op = TB_READ; tb_id = bp_id[hent]; end
          end else if (vkill) begin
            tb_valid = 1'b1; tb_op = TB_KILL; tb_id = bp_id[vent];
          end else begin
            tb_valid = 1'b1; tb_op = TB_LOAD; tb_tbl = '0;
          end
        OP_VICT:
          if (bp_v[ptr_q]) begin tb_valid = 1'b1; tb_op = TB_SLOT; tb_id = bp_id[ptr_q]; end
        OP_PROBE:
          if (hit && bp_v[hent]) begin tb_valid = 1'b1; tb_op = TB_READ; tb_id = bp_id[hent]; end
        default: ;
      endcase
      S_WR:  begin tb_valid = 1'b1; tb_op = TB_LOAD; end
      S_INV: begin tb_valid = 1'b1; tb_op = TB_KILL; tb_id = old_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_ptr <= '0; rsp_loc <= '0;
      op_q <= '0; pa_q <= '0; bid_q <= '0; old_q <= '0; ptr_q <= '0; eptr_q <= '0;
      slot_q <= '0; way_q <= '0; tbl_q <= '0; syn_q <= 1'b0; rr <= '0;
      for (int i = 0; i < ENT; i++) begin d_v[i] <= 1'b0; bp_v[i] <= 1'b0; end
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; pa_q <= req_page; bid_q <= req_bid; ptr_q <= req_ptr;
          slot_q <= req_slot; way_q <= req_way; tbl_q <= req_tbl; st <= S_EXEC;
        end
        S_EXEC: case (op_q)
          OP_MISS:
            if (hit) begin
              eptr_q <= hent; rsp_ptr <= hent; rsp_hit <= 1'b1;
              if (!bp_v[hent]) begin
                bp_v[hent] <= 1'b1; bp_id[hent] <= bid_q; rsp_valid <= 1'b1; st <= S_IDLE;
              end else if (bp_id[hent] == bid_q) begin
                rsp_valid <= 1'b1; st <= S_IDLE;
              end else begin
                old_q <= bp_id[hent]; syn_q <= 1'b1; st <= S_RD;
              end
            end else begin
              d_v[vent] <= 1'b1; d_tag[vent] <= tag_q; d_tab[vent] <= '0;
              bp_v[vent] <= 1'b1; bp_id[vent] <= bid_q;
              rsp_ptr <= vent; rsp_hit <= 1'b0;
              if (!ffree && !fownok) rr <= rr + 1'b1;
              if (vkill) begin tbl_q <= '0; syn_q <= 1'b0; st <= S_WR; end
              else begin rsp_valid <= 1'b1; st <= S_IDLE; end
            end
          OP_EVICT: begin
            if (d_v[ptr_q] && bp_v[ptr_q] && bp_id[ptr_q] == bid_q) begin
              d_tab[ptr_q] <= tbl_q; bp_v[ptr_q] <= 1'b0; rsp_hit <= 1'b1;
            end else rsp_hit <= 1'b0;
            rsp_valid <= 1'b1; st <= S_IDLE;
          end
          OP_VICT: begin
            if (!bp_v[ptr_q]) d_tab[ptr_q][int'(slot_q)*SLOTW +: SLOTW] <= {2'b11, way_q};
            rsp_hit <= bp_v[ptr_q]; rsp_valid <= 1'b1; st <= S_IDLE;
          end
          default: begin
            rsp_hit <= hit; rsp_ptr <= hent;
            if (hit && bp_v[hent]) st <= S_RD;
            else begin
              rsp_loc <= hit ? d_tab[hent][int'(slot_q)*SLOTW +: SLOTW] : '0;
              rsp_valid <= 1'b1; st <= S_IDLE;
            end
          end
        endcase
        S_RD: if (tb_rsp_valid) begin
          if (op_q == OP_PROBE) begin
            rsp_loc <= tb_rsp_tbl[int'(slot_q)*SLOTW +: SLOTW]; rsp_valid <= 1'b1; st <= S_IDLE;
          end else begin
            tbl_q <= tb_rsp_tbl; st <= S_WR;
          end
        end
        S_WR: if (syn_q) st <= S_INV;
              else begin rsp_valid <= 1'b1; st <= S_IDLE; end
        default: begin
          bp_id[eptr_q] <= bid_q; rsp_valid <= 1'b1; st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/page_loc_dir_chk.sv
`timescale 1ns/1ps
module page_loc_dir_chk #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [LW-1:0] rsp_loc,
  input logic          tb_valid,
  input logic [1:0]    tb_op,
  input logic          tb_rsp_valid
);
  logic [1:0] acc_op;
  always_ff @(posedge clk) begin
    if (!rst_n) acc_op <= 2'd0;
    else if (req_valid && !busy) acc_op <= req_op;
  end

  AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) tb_valid |-> busy); // R9
  AST_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !busy); // R9
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (tb_valid && tb_op == 2'd0) |=> !tb_valid); // R4
  AST_HANDOFF_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_valid && tb_op == 2'd1 && $past(tb_rsp_valid)) |=> (tb_valid && tb_op == 2'd2)); // R4
  AST_PROBE_MISS_NC: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && acc_op == 2'd3 && !rsp_hit) |-> rsp_loc == '0); // R8
endmodule

bind page_loc_dir page_loc_dir_chk #(.LW(LWAYW + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_loc(rsp_loc), .tb_valid(tb_valid),
  .tb_op(tb_op), .tb_rsp_valid(tb_rsp_valid)
);

// File: tb/test_page_loc_dir.sv
`timescale 1ns/1ps
module test_page_loc_dir;
  localparam logic [1:0] MISS = 2'd0, EVICT = 2'd1, VICT = 2'd2, PROBE = 2'd3;
  localparam logic [1:0] RD = 2'd0, LD = 2'd1, KL = 2'd2, SL = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [3:0] req_page = '0;
  logic [2:0] req_bid = '0;
  logic [1:0] req_ptr = '0, req_slot = '0, req_way = '0;
  logic [15:0] req_tbl = '0;
  logic busy, rsp_valid, rsp_hit, tb_valid;
  logic [1:0] rsp_ptr, tb_op, tb_slot;
  logic [3:0] rsp_loc, tb_loc;
  logic [2:0] tb_id;
  logic [15:0] tb_tbl;
  logic tb_rsp_valid = 1'b0;
  logic [15:0] tb_rsp_tbl = '0;

  page_loc_dir #(.PAW(4), .SETS(2), .WAYS(2), .LINES(4), .LWAYW(2), .BIDW(3)) i_page_loc_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_page(req_page),
    .req_bid(req_bid), .req_ptr(req_ptr), .req_slot(req_slot), .req_way(req_way),
    .req_tbl(req_tbl), .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_ptr(rsp_ptr), .rsp_loc(rsp_loc), .tb_valid(tb_valid), .tb_op(tb_op), .tb_id(tb_id),
    .tb_slot(tb_slot), .tb_loc(tb_loc), .tb_tbl(tb_tbl), .tb_rsp_valid(tb_rsp_valid),
    .tb_rsp_tbl(tb_rsp_tbl));

  logic [15:0] btab [8];
  logic [1:0]  lop [256];
  logic [2:0]  lid [256];
  logic [15:0] ldat [256];
  int ncmd = 0, nrsp = 0, nchk = 0, nerr = 0;
  logic r_hit;
  logic [1:0] r_ptr;
  logic [3:0] r_loc;

  initial for (int i = 0; i < 8; i++) btab[i] = '0;

  always @(posedge clk) begin
    tb_rsp_valid <= 1'b0;
    if (rsp_valid) nrsp <= nrsp + 1;
    if (tb_valid) begin
      lop[ncmd[7:0]] <= tb_op; lid[ncmd[7:0]] <= tb_id; ldat[ncmd[7:0]] <= tb_tbl;
      ncmd <= ncmd + 1;
      case (tb_op)
        RD: begin tb_rsp_valid <= 1'b1; tb_rsp_tbl <= btab[tb_id]; end
        LD: btab[tb_id] <= tb_tbl;
        SL: btab[tb_id][int'(tb_slot)*4 +: 4] <= tb_loc;
        default: ;
      endcase
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_cmd(string req, int k, logic [1:0] op, logic [2:0] id);
    check(req, {28'd0, lop[k[7:0]], 2'd0}, {28'd0, op, 2'd0});
    check(req, {29'd0, lid[k[7:0]]}, {29'd0, id});
  endtask

  task automatic do_req(logic [1:0] op, logic [3:0] pg, logic [2:0] bid, logic [1:0] ptr,
                        logic [1:0] slot, logic [1:0] way, logic [15:0] tbl);
    @(negedge clk);
    req_op = op; req_page = pg; req_bid = bid; req_ptr = ptr; req_slot = slot;
    req_way = way; req_tbl = tbl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && !rsp_valid; i++) @(negedge clk);
    r_hit = rsp_hit; r_ptr = rsp_ptr; r_loc = rsp_loc;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int c0, n0;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    check("R1 tb_valid", {31'd0, tb_valid}, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 16; p++) begin
      c0 = ncmd;
      do_req(PROBE, 4'(p), 3'd0, 2'd0, 2'(p), 2'd0, 16'd0);
      check("R1 R8 probe miss hit", {31'd0, r_hit}, 0);
      check("R8 probe miss loc", {28'd0, r_loc}, 0);
      check("R1 no cmd", ncmd - c0, 0);
    end
    // R3 installs into invalid ways: ptr = set*2 + way
    c0 = ncmd; do_req(MISS, 4'd0, 3'd0, 0, 0, 0, 0);
    check("R3 hit", {31'd0, r_hit}, 0); check("R3 ptr", {30'd0, r_ptr}, 0);
    check("R3 ncmd", ncmd - c0, 1); chk_cmd("R3 load", c0, LD, 0);
    check("R3 zero table", {16'd0, ldat[c0[7:0]]}, 0);
    c0 = ncmd; do_req(MISS, 4'd2, 3'd1, 0, 0, 0, 0);
    check("R3 ptr way1", {30'd0, r_ptr}, 1); chk_cmd("R3 load", c0, LD, 1);
    c0 = ncmd; do_req(MISS, 4'd1, 3'd2, 0, 0, 0, 0);
    check("R3 ptr set1", {30'd0, r_ptr}, 2); chk_cmd("R3 load", c0, LD, 2);
    // R7 owned victim update
    c0 = ncmd; do_req(VICT, 0, 0, 2'd0, 2'd2, 2'd3, 0);
    check("R7 ncmd", ncmd - c0, 1); chk_cmd("R7 slot cmd", c0, SL, 0);
    check("R7 buffer table", {16'd0, btab[0]}, 32'h0F00);
    c0 = ncmd; do_req(PROBE, 4'd0, 0, 0, 2'd2, 0, 0);
    chk_cmd("R8 owner read", c0, RD, 0);
    check("R8 hit", {31'd0, r_hit}, 1); check("R8 loc owner", {28'd0, r_loc}, 4'hF);
    // R6 write-back
    c0 = ncmd; do_req(EVICT, 0, 3'd0, 2'd0, 0, 0, 16'h0F00);
    check("R6 match", {31'd0, r_hit}, 1); check("R6 no cmd", ncmd - c0, 0);
    c0 = ncmd; do_req(PROBE, 4'd0, 0, 0, 2'd2, 0, 0);
    check("R6 dir loc", {28'd0, r_loc}, 4'hF); check("R6 R8 no read", ncmd - c0, 0);
    do_req(EVICT, 0, 3'd5, 2'd1, 0, 0, 16'hFFFF);
    check("R6 mismatch", {31'd0, r_hit}, 0);
    c0 = ncmd; do_req(PROBE, 4'd2, 0, 0, 2'd0, 0, 0);
    check("R6 ignored owner kept", ncmd - c0, 1); chk_cmd("R6 ignored read", c0, RD, 1);
    check("R6 ignored loc", {28'd0, r_loc}, 0);
    // R7 unowned victim update
    c0 = ncmd; do_req(VICT, 0, 0, 2'd0, 2'd1, 2'd2, 0);
    check("R7 no cmd", ncmd - c0, 0);
    do_req(PROBE, 4'd0, 0, 0, 2'd1, 0, 0);
    check("R7 dir slot", {28'd0, r_loc}, 4'hE);
    // R2 hit without owner
    c0 = ncmd; do_req(MISS, 4'd0, 3'd3, 0, 0, 0, 0);
    check("R2 hit", {31'd0, r_hit}, 1); check("R2 ptr", {30'd0, r_ptr}, 0);
    check("R2 ncmd", ncmd - c0, 1); chk_cmd("R2 load", c0, LD, 3);
    check("R2 table", {16'd0, ldat[c0[7:0]]}, 32'h0FE0);
    c0 = ncmd; do_req(PROBE, 4'd0, 0, 0, 2'd1, 0, 0);
    chk_cmd("R2 owner read", c0, RD, 3); check("R2 loc", {28'd0, r_loc}, 4'hE);
    c0 = ncmd; do_req(MISS, 4'd0, 3'd3, 0, 0, 0, 0);
    check("R4 own repeat no cmd", ncmd - c0, 0);
    // R4 synonym
    c0 = ncmd; do_req(MISS, 4'd0, 3'd0, 0, 0, 0, 0);
    check("R4 ncmd", ncmd - c0, 3); check("R4 hit", {31'd0, r_hit}, 1);
    chk_cmd("R4 read old", c0, RD, 3); chk_cmd("R4 load new", c0 + 1, LD, 0);
    check("R4 table", {16'd0, ldat[(c0 + 1) & 255]}, 32'h0FE0);
    chk_cmd("R4 kill old", c0 + 2, KL, 3);
    c0 = ncmd; do_req(PROBE, 4'd0, 0, 0, 0, 0, 0);
    chk_cmd("R4 new owner", c0, RD, 0);
    // R5 data to instruction side
    c0 = ncmd; do_req(MISS, 4'd0, 3'd4, 0, 0, 0, 0);
    check("R5 ncmd", ncmd - c0, 3);
    chk_cmd("R5 read d", c0, RD, 0); chk_cmd("R5 load i", c0 + 1, LD, 4);
    chk_cmd("R5 kill d", c0 + 2, KL, 0);
    // R9 requests during a sequence are ignored
    c0 = ncmd; n0 = nrsp;
    @(negedge clk);
    req_op = MISS; req_page = 4'd0; req_bid = 3'd5; req_valid = 1'b1;
    @(negedge clk);
    check("R9 busy", {31'd0, busy}, 1);
    req_op = PROBE; req_page = 4'd1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 one rsp", nrsp - n0, 1); check("R9 ncmd", ncmd - c0, 3);
    chk_cmd("R9 seq", c0 + 1, LD, 5);
    check("R9 idle", {31'd0, busy}, 0);
    // R3 victim choice
    do_req(EVICT, 0, 3'd1, 2'd1, 0, 0, 16'd0);
    c0 = ncmd; do_req(MISS, 4'd4, 3'd6, 0, 0, 0, 0);
    check("R3 unowned way", {30'd0, r_ptr}, 1); check("R3 no kill", ncmd - c0, 1);
    do_req(PROBE, 4'd2, 0, 0, 0, 0, 0);
    check("R3 replaced page", {31'd0, r_hit}, 0);
    c0 = ncmd; do_req(MISS, 4'd6, 3'd7, 0, 0, 0, 0);
    check("R3 rr way0", {30'd0, r_ptr}, 0); check("R3 ncmd", ncmd - c0, 2);
    chk_cmd("R3 kill", c0, KL, 5); chk_cmd("R3 load", c0 + 1, LD, 7);
    check("R3 load zero", {16'd0, ldat[(c0 + 1) & 255]}, 0);
    do_req(PROBE, 4'd0, 0, 0, 0, 0, 0);
    check("R3 evicted page", {31'd0, r_hit}, 0);
    c0 = ncmd; do_req(MISS, 4'd8, 3'd6, 0, 0, 0, 0);
    check("R3 rr way1", {30'd0, r_ptr}, 1); chk_cmd("R3 kill rot", c0, KL, 6);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule